// File: doc/BRIEF.md
# Complex Interpolate-by-Three Polyphase FIR

This block raises the sample rate of a complex stream by a factor of three. The result is exactly what you would get from the following reference steps. First, each input sample is followed by two zero samples. Next, the stuffed stream is convolved with one prototype filter of 3T taps. Finally, every full-precision sum is rounded and clipped to 16 bits.

The block never multiplies the stuffed zeros. It holds the last T input samples in a delay line. For each accepted sample it evaluates three sub-filters, one per output phase. Sub-filter p uses prototype taps p, p+3, p+6 and so on.

I and Q pass through the same real coefficients. The coefficients are 18-bit signed values written through a simple address/data port. Results leave on two parallel lanes, one for even output indices and one for odd ones. A pair is delivered once for every two results.

Top module: `interp3_cfir`

## Requirements
- R1: After a synchronous active-low reset, the state is as follows. in_ready is 1 and out_valid is 0. All delay-line samples, all coefficients and the lane pairing state are zero, so samples sent before any coefficient write give zero outputs.
- R2: A sample is accepted on a rising clock edge where in_valid and in_ready are both 1. in_ready is then 0 for the next three cycles and returns to 1 in the fourth.
- R3: Let the prototype taps be h[0..3T-1] and the accepted samples since reset be x[0], x[1], and so on, with earlier samples counted as zero. Output m equals the value sum over j of h[j]*u[m-j], rounded and saturated. Here u[3n] = x[n] and u is zero at every other index.
- R4: Each accepted sample x[n] produces outputs 3n, 3n+1 and 3n+2, in that order. Output 3n+p uses only the taps whose index modulo 3 equals p.
- R5: Rounding removes the 15 low bits, with ties going toward positive infinity. The result is floor((v + 16384) / 32768); for example, 16384 gives 1, -16384 gives 0 and -49152 gives -1.
- R6: The rounded value is clipped to the range -32768 to 32767 before it is output.
- R7: Outputs are paired in order. out0_* carries output 2k and out1_* carries output 2k+1, both valid in the single cycle where out_valid is 1. Two pairs are never valid in consecutive cycles.
- R8: When coef_we is 1 on a clock edge, coef_data is stored as prototype tap h[coef_addr]. A write whose address is 3T or above is ignored.
- R9: The I and Q parts are filtered independently with the same coefficients, so the data on one part never changes the result on the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample |
| in_i | input | 16 | Input real part, signed |
| in_q | input | 16 | Input imaginary part, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Prototype tap index (default T=4) |
| coef_data | input | 18 | Coefficient value, signed |
| out_valid | output | 1 | Output pair valid |
| out0_i | output | 16 | Even-indexed output, real part |
| out0_q | output | 16 | Even-indexed output, imaginary part |
| out1_i | output | 16 | Odd-indexed output, real part |
| out1_q | output | 16 | Odd-indexed output, imaginary part |

## Verification
Each internal fault shows at the ports within a known number of cycles or pairs:

- **Delay line:** a slipped or uncleared delay line corrupts outputs from the second accepted sample onward, as soon as a non-zero tap beyond the first is loaded.
- **Phase counter:** a wrong counter puts taps of the wrong residue into a result. This is visible within one input sample when only one prototype tap is non-zero, so the bench sweeps the impulse coefficient over every tap position.
- **Lane pairing:** a parity fault swaps or drops results in the first or second pair.
- **Rounding and clipping:** faults appear only at exact ties and extreme sums, which dedicated runs target directly.

// File: rtl/interp3_pkg.sv
// Shared constants for the interpolate-by-three filter.
// Assumes: the interpolation factor is fixed at three by design.
package interp3_pkg;
    localparam int unsigned NUM_PHASES = 3;
    localparam int unsigned PHASE_W    = 2;
endpackage

// File: rtl/interp3_delay.sv
// Complex sample delay line: tap[0] holds the newest accepted sample and
// tap[k] the sample accepted k acceptances earlier.
// Assumes: shift is a single-cycle strobe per accepted sample.
module interp3_delay #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] din_i,
    input  logic signed [DATA_W-1:0] din_q,
    output logic signed [DATA_W-1:0] tap_i [DEPTH],
    output logic signed [DATA_W-1:0] tap_q [DEPTH]
);
    // Shift the new sample in and age every stored sample by one position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                tap_i[k] <= '0;
                tap_q[k] <= '0;
            end
        end else if (shift) begin
            tap_i[0] <= din_i;
            tap_q[0] <= din_q;
            for (int k = 1; k < DEPTH; k++) begin
                tap_i[k] <= tap_i[k-1];
                tap_q[k] <= tap_q[k-1];
            end
        end
    end

    generate
        if (DEPTH > 1) begin : g_age_check
            p_delay_ages_r3: assert property (@(posedge clk) disable iff (!rst_n)
                shift |=> (tap_i[1] == $past(tap_i[0])) && (tap_q[1] == $past(tap_q[0])));
        end
    endgenerate
endmodule

// File: rtl/interp3_mac.sv
// Sum of products of one sub-filter: T samples times T coefficients.
// Purely combinational; the accumulator width leaves no room for overflow.
module interp3_mac #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 18,
    parameter int TAPS   = 4,
    parameter int ACC_W  = 37
) (
    input  logic signed [DATA_W-1:0] smp  [TAPS],
    input  logic signed [COEF_W-1:0] coef [TAPS],
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic signed [PROD_W-1:0] prod [TAPS];

    generate
        for (genvar k = 0; k < TAPS; k++) begin : g_prod
            assign prod[k] = smp[k] * coef[k];
        end
    endgenerate

    // Add the sign-extended products into the wide accumulator.
    always_comb begin
        acc = '0;
        for (int k = 0; k < TAPS; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
    end
endmodule

// File: rtl/interp3_rndsat.sv
// Drops CUT low bits with ties toward +infinity, then clips to OUT_W signed.
// Assumes ACC_W > CUT + OUT_W so the clip bounds are representable.
module interp3_rndsat #(
    parameter int ACC_W = 37,
    parameter int CUT   = 15,
    parameter int OUT_W = 16
) (
    input  logic signed [ACC_W-1:0] din,
    output logic signed [OUT_W-1:0] dout
);
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< (CUT - 1);
    localparam logic signed [SUM_W-1:0] MAXV = (SUM_W'(1) <<< (OUT_W - 1)) - SUM_W'(1);
    localparam logic signed [SUM_W-1:0] MINV = -MAXV - SUM_W'(1);

    logic signed [SUM_W-1:0] biased;
    logic signed [SUM_W-1:0] shifted;

    // Add half an output LSB, shift arithmetically, clip to the output range.
    always_comb begin
        biased  = SUM_W'(din) + HALF;
        shifted = biased >>> CUT;
        if (shifted > MAXV)      dout = MAXV[OUT_W-1:0];
        else if (shifted < MINV) dout = MINV[OUT_W-1:0];
        else                     dout = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/interp3_cfir.sv
// Complex interpolate-by-three polyphase FIR with two output lanes.
// Each accepted sample is followed by three compute cycles (phases 0,1,2);
// results are paired so that even outputs leave on lane 0, odd on lane 1.
// Assumes the coefficient port is written while the block is idle.
module interp3_cfir
    import interp3_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int COEF_W         = 18,
    parameter int TAPS_PER_PHASE = 4,
    parameter int CUT_BITS       = 15,
    localparam int NTAPS  = NUM_PHASES * TAPS_PER_PHASE,
    localparam int ADDR_W = $clog2(NTAPS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    input  logic                     coef_we,
    input  logic [ADDR_W-1:0]        coef_addr,
    input  logic signed [COEF_W-1:0] coef_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out0_i,
    output logic signed [DATA_W-1:0] out0_q,
    output logic signed [DATA_W-1:0] out1_i,
    output logic signed [DATA_W-1:0] out1_q
);
    localparam int ACC_W = DATA_W + COEF_W + $clog2(TAPS_PER_PHASE) + 1;
    localparam logic [PHASE_W-1:0] LAST_PHASE = PHASE_W'(NUM_PHASES - 1);

    logic                     busy;
    logic [PHASE_W-1:0]       phase;
    logic                     accept;
    logic                     lane_odd;
    logic signed [COEF_W-1:0] coef_mem [NTAPS];
    logic signed [COEF_W-1:0] ph_coef  [TAPS_PER_PHASE];
    logic signed [DATA_W-1:0] tap_i    [TAPS_PER_PHASE];
    logic signed [DATA_W-1:0] tap_q    [TAPS_PER_PHASE];
    logic signed [ACC_W-1:0]  acc_i, acc_q;
    logic signed [DATA_W-1:0] y_i, y_q;
    logic signed [DATA_W-1:0] hold_i, hold_q;

    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    // Coefficient bank: store writes that fall inside the prototype.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NTAPS; j++) coef_mem[j] <= '0;
        end else if (coef_we && (int'(coef_addr) < NTAPS)) begin
            coef_mem[coef_addr] <= coef_data;
        end
    end

    // Select every third prototype tap, starting at the current phase.
    generate
        for (genvar k = 0; k < TAPS_PER_PHASE; k++) begin : g_phase_sel
            assign ph_coef[k] = coef_mem[NUM_PHASES * k + int'(phase)];
        end
    endgenerate

    // Sequencer: after an accept, step through the three phases, then idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            phase <= '0;
        end else if (busy) begin
            if (phase == LAST_PHASE) begin
                busy  <= 1'b0;
                phase <= '0;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    interp3_delay #(.DATA_W(DATA_W), .DEPTH(TAPS_PER_PHASE)) u_delay (
        .clk(clk), .rst_n(rst_n), .shift(accept),
        .din_i(in_i), .din_q(in_q), .tap_i(tap_i), .tap_q(tap_q)
    );

    interp3_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS_PER_PHASE), .ACC_W(ACC_W))
        u_mac_i (.smp(tap_i), .coef(ph_coef), .acc(acc_i));
    interp3_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .TAPS(TAPS_PER_PHASE), .ACC_W(ACC_W))
        u_mac_q (.smp(tap_q), .coef(ph_coef), .acc(acc_q));

    interp3_rndsat #(.ACC_W(ACC_W), .CUT(CUT_BITS), .OUT_W(DATA_W))
        u_rs_i (.din(acc_i), .dout(y_i));
    interp3_rndsat #(.ACC_W(ACC_W), .CUT(CUT_BITS), .OUT_W(DATA_W))
        u_rs_q (.din(acc_q), .dout(y_q));

    // Lane pairing: park even results, emit a pair with each odd result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_odd  <= 1'b0;
            out_valid <= 1'b0;
            hold_i    <= '0;
            hold_q    <= '0;
            out0_i    <= '0;
            out0_q    <= '0;
            out1_i    <= '0;
            out1_q    <= '0;
        end else begin
            out_valid <= 1'b0;
            if (busy) begin
                if (!lane_odd) begin
                    hold_i   <= y_i;
                    hold_q   <= y_q;
                    lane_odd <= 1'b1;
                end else begin
                    out0_i    <= hold_i;
                    out0_q    <= hold_q;
                    out1_i    <= y_i;
                    out1_q    <= y_q;
                    out_valid <= 1'b1;
                    lane_odd  <= 1'b0;
                end
            end
        end
    end

    p_ready_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !in_ready);

    p_phase_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase != LAST_PHASE && !accept) |=> (busy && phase == $past(phase) + 1'b1));

    p_pair_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_pair_from_compute_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(busy));
endmodule

// File: tb/interp3_cfir_test.sv
module interp3_cfir_test;
    localparam int CLK_PERIOD = 10;
    localparam int T  = 4;
    localparam int NT = 3 * T;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic coef_we = 1'b0;
    logic [3:0] coef_addr = '0;
    logic signed [17:0] coef_data = '0;
    logic out_valid;
    logic signed [15:0] out0_i, out0_q, out1_i, out1_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int h  [NT];
    int xi [16];
    int xq [16];
    int cap0_i [64], cap0_q [64], cap1_i [64], cap1_q [64];
    int cap_n = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    interp3_cfir #(.TAPS_PER_PHASE(T)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .out_valid(out_valid),
        .out0_i(out0_i), .out0_q(out0_q), .out1_i(out1_i), .out1_q(out1_q)
    );

    always @(negedge clk) begin
        if (rst_n && out_valid && cap_n < 64) begin
            cap0_i[cap_n] = out0_i; cap0_q[cap_n] = out0_q;
            cap1_i[cap_n] = out1_i; cap1_q[cap_n] = out1_q;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0d expected=%0d", req, got, exp);
        end
    endtask

    function automatic int rnd_sat(input longint v);
        longint r;
        r = (v + 64'sd16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    // Reference: zero-stuff by three, direct convolution, round, saturate.
    function automatic int model(input int m, input bit q);
        longint acc = 0;
        for (int j = 0; j < NT; j++) begin
            if (m - j >= 0 && (m - j) % 3 == 0)
                acc += longint'(h[j]) * longint'(q ? xq[(m-j)/3] : xi[(m-j)/3]);
        end
        return rnd_sat(acc);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0;
    endtask

    task automatic load_coefs();
        for (int j = 0; j < NT; j++) begin
            coef_we = 1'b1; coef_addr = 4'(j); coef_data = 18'(h[j]);
            @(negedge clk);
        end
        // Out-of-range addresses must be ignored (R8).
        for (int j = NT; j < 16; j++) begin
            coef_we = 1'b1; coef_addr = 4'(j); coef_data = 18'sd77777;
            @(negedge clk);
        end
        coef_we = 1'b0;
    endtask

    task automatic send(input int vi, input int vq);
        in_valid = 1'b1; in_i = 16'(vi); in_q = 16'(vq);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run(input int n, input bit load, input string req);
        do_reset();
        if (load) load_coefs();
        for (int s = 0; s < n; s++) send(xi[s], xq[s]);
        repeat (10) @(negedge clk);
        chk({req, " R7 pair count"}, cap_n, (3 * n) / 2);
        for (int p = 0; p < cap_n; p++) begin
            chk({req, " R7 lane0 I"}, cap0_i[p], model(2*p, 1'b0));
            chk({req, " R9 lane0 Q"}, cap0_q[p], model(2*p, 1'b1));
            chk({req, " R7 lane1 I"}, cap1_i[p], model(2*p+1, 1'b0));
            chk({req, " R9 lane1 Q"}, cap1_q[p], model(2*p+1, 1'b1));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        do_reset();
        chk("R1 in_ready", int'(in_ready), 1);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 out0_i", int'(out0_i), 0);
        chk("R1 out1_q", int'(out1_q), 0);

        // R2: ready low for three cycles after an accept.
        send(1234, -99);
        chk("R2 ready low 1", int'(in_ready), 0);
        @(negedge clk); chk("R2 ready low 2", int'(in_ready), 0);
        @(negedge clk); chk("R2 ready low 3", int'(in_ready), 0);
        @(negedge clk); chk("R2 ready back", int'(in_ready), 1);

        // R1: coefficients clear on reset, so outputs are zero.
        for (int j = 0; j < NT; j++) h[j] = 0;
        for (int s = 0; s < 4; s++) begin xi[s] = 30000 - s; xq[s] = -20000 + s; end
        run(4, 1'b0, "R1 cleared coefs");

        // R3 R4 R8: single-tap sweep across every prototype position.
        for (int t = 0; t < NT; t++) begin
            for (int j = 0; j < NT; j++) h[j] = (j == t) ? 32768 : 0;
            for (int s = 0; s < 6; s++) begin
                xi[s] = 1000 * (s + 1) - 3500;
                xq[s] = -777 * (s + 2);
            end
            run(6, 1'b1, "R4 tap sweep");
        end

        // R3 R9: random coefficients and data.
        for (int r = 0; r < 6; r++) begin
            for (int j = 0; j < NT; j++) h[j] = int'($urandom_range(0, 65535)) - 32768;
            for (int s = 0; s < 16; s++) begin
                xi[s] = int'($urandom_range(0, 65535)) - 32768;
                xq[s] = int'($urandom_range(0, 65535)) - 32768;
            end
            run(16, 1'b1, "R3 random");
        end

        // R6: saturation at both extremes.
        for (int j = 0; j < NT; j++) h[j] = 131071;
        for (int s = 0; s < 8; s++) begin
            xi[s] = (s < 4) ? 32767 : -32768;
            xq[s] = (s < 4) ? -32768 : 32767;
        end
        run(8, 1'b1, "R6 saturate");
        chk("R6 positive clip", cap0_i[4], 32767);
        chk("R6 negative clip", cap0_q[4], -32768);

        // R5: rounding ties and near-ties with a single unit tap.
        for (int j = 0; j < NT; j++) h[j] = (j == 0) ? 1 : 0;
        xi[0] = 16384; xi[1] = -16384; xi[2] = 16385; xi[3] = -16385;
        xq[0] = 16383; xq[1] = -16383; xq[2] = 0;     xq[3] = 32767;
        run(4, 1'b1, "R5 ties");
        chk("R5 +0.5 -> 1", cap0_i[0], 1);
        chk("R5 -0.5 -> 0", cap1_i[1], 0);
        chk("R5 -0.50003 -> -1", cap1_i[4], -1);

        for (int j = 0; j < NT; j++) h[j] = (j == 0) ? 3 : 0;
        xi[0] = -16384; xi[1] = 16384;
        xq[0] = 10923;  xq[1] = -10923;
        run(2, 1'b1, "R5 ties x3");
        chk("R5 -1.5 -> -1", cap0_i[0], -1);
        chk("R5 +1.5 -> 2", cap1_i[1], 2);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule